// File: doc/BRIEF.md
# Accumulating Multi-Slot Conversion Result Bank

This block sits between a register bus and one shared analog-to-digital converter. It holds eight conversion slots. Each slot points at one of sixteen physical inputs through a slot map. A start request for a slot can come from a bus write or from a per-slot trigger pulse. The request waits until the converter is free. The converter is then asked for a conversion of the mapped input. When the result comes back, the slot either stores it as is or adds it to a running sum. The slot raises its completion flag once its programmed number of samples has been taken.

In accumulate mode a slot is programmed with a count of N−1, sums N results and flags after the N-th; the consumer divides by N. Some inputs can be handed to touch-sensing features. A touch-button feature takes inputs 0 and 1, a four-wire panel takes inputs 2 to 5, and a five-wire panel takes inputs 2 to 6. The bank refuses a slot map or slot-enable mask that would convert a taken input, or that would use more slots than remain once each active feature has kept one slot for itself. Completion flags for the eight slots and for five outside events share one interrupt register with matching enables. The interrupt output is high while any enabled flag is set.

Register offsets: start 0x000, interrupt 0x010, interrupt clear alias 0x018, feature setup 0x020, slot enable mask 0x030, slot map 0x140, slot n result 0x050 + 0x10·n.

Top module: `lradc_bank`

## Requirements
- R1: After reset every register reads 0, `cnv_req_o` is low and `irq_o` is low.
- R2: Slot n converts the input named by slot-map bits [4n+3:4n]. That value is driven on `cnv_chan_o`, which stays stable while `cnv_req_o` is high.
- R3: With accumulate bit 29 of a slot result register clear, a conversion stores its 18-bit result in bits [17:0] of that register and sets interrupt flag bit n.
- R4: With bit 29 set and count field [28:24] = N−1, each result is added to bits [17:0] modulo 2^18. Flag bit n is set only on the N-th conversion.
- R5: Any write to a slot result register loads bits [17:0], 29 and [28:24] as written and restarts that slot's sample counter from zero.
- R6: Writing 1 to bit n of the start register (0x000), or pulsing `trig_i[n]`, starts slot n. This happens only when bit n of the enable mask (0x030) is set; otherwise the start has no effect.
- R7: At most one conversion is outstanding (`cnv_req_o` held until `cnv_done_i`). Pending slots are served lowest index first.
- R8: `irq_o` is high exactly when some flag bit [12:0] of register 0x010 is set together with its enable at bit position +16. `evt_i[k]` sets flag bit 8+k. A write to 0x010 loads only the enables.
- R9: Writing 1s to alias 0x018 clears the corresponding flag bits [12:0] and enable bits [28:16]. Other bits are kept.
- R10: A slot-map or enable-mask write is dropped (register unchanged) if any enabled slot would then map to a reserved input. Feature register bit 0 reserves inputs 0–1. Bits [2:1] = 1 reserve inputs 2–5, and bits [2:1] = 2 reserve inputs 2–6.
- R11: A slot-map or enable-mask write is dropped if the number of enabled slots plus one per active feature would exceed 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 9 | Write byte address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 9 | Read byte address |
| bus_rdata | output | 32 | Read data (combinational) |
| trig_i | input | 8 | Per-slot start pulses |
| evt_i | input | 5 | Outside event pulses, set flags 8–12 |
| cnv_req_o | output | 1 | Conversion request to the converter |
| cnv_chan_o | output | 4 | Physical input to convert |
| cnv_done_i | input | 1 | Converter result valid pulse |
| cnv_data_i | input | 18 | Converter result |
| irq_o | output | 1 | Interrupt, OR of enabled flags |

## Verification
A single-slot start shows that the slot map reaches the converter and that a direct result lands in the right register. Several slots started in one write, and random start masks over random maps, separate the lowest-first order from any other order and catch a wrong slot index in the map lookup. Accumulation is run with random 18-bit results, so the sum wraps and the flag timing shows whether the counter compares against N−1. A counter rewritten mid-round shows whether it restarts. Dropped map and mask writes are read back under each reservation mode, both at the slot-count limit and just past it.

// File: rtl/lradc_bank_pkg.sv
// Shared constants and types for the conversion result bank.
// Assumes the fixed register layout of eight slots and sixteen inputs.
package lradc_bank_pkg;
    localparam int BANK_SLOTS  = 8;
    localparam int BANK_CHANS  = 16;
    localparam int BANK_VAL_W  = 18;
    localparam int BANK_NS_W   = 5;
    localparam int BANK_EVT    = 5;
    localparam int BANK_AW     = 9;
    localparam int BANK_DW     = 32;
    localparam int ACC_BIT     = 29;
    localparam int NS_LSB      = 24;
    localparam int EN_LSB      = 16;
    localparam int ADR_START   = 'h000;
    localparam int ADR_IRQ     = 'h010;
    localparam int ADR_IRQ_CLR = 'h018;
    localparam int ADR_FEAT    = 'h020;
    localparam int ADR_MASK    = 'h030;
    localparam int ADR_MAP     = 'h140;
    localparam int ADR_SLOT0   = 'h050;
    localparam int SLOT_STRIDE = 'h010;

    typedef enum logic [1:0] {
        PANEL_OFF  = 2'd0,
        PANEL_FOUR = 2'd1,
        PANEL_FIVE = 2'd2,
        PANEL_NA   = 2'd3
    } panel_mode_e;
endpackage

// File: rtl/lradc_slot.sv
// One conversion slot: holds the result field, accumulate enable and
// sample count, and counts results within an accumulation round.
// Assumes hit is a single-cycle pulse; a config write wins over a hit.
module lradc_slot #(
    parameter int VAL_W = 18,
    parameter int NS_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [VAL_W-1:0] cfg_val,
    input  logic             cfg_acc,
    input  logic [NS_W-1:0]  cfg_ns,
    input  logic             hit,
    input  logic [VAL_W-1:0] res,
    output logic [VAL_W-1:0] val_o,
    output logic             acc_o,
    output logic [NS_W-1:0]  ns_o,
    output logic             complete_o
);
    logic [VAL_W-1:0] val_q;
    logic             acc_q;
    logic [NS_W-1:0]  ns_q;
    logic [NS_W-1:0]  cnt_q;

    // Load configuration, or store / accumulate a returning result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            acc_q <= 1'b0;
            ns_q  <= '0;
            cnt_q <= '0;
        end else if (cfg_we) begin
            val_q <= cfg_val;
            acc_q <= cfg_acc;
            ns_q  <= cfg_ns;
            cnt_q <= '0;
        end else if (hit) begin
            if (acc_q) begin
                val_q <= val_q + res;
                cnt_q <= (cnt_q == ns_q) ? '0 : cnt_q + 1'b1;
            end else begin
                val_q <= res;
            end
        end
    end

    assign complete_o = hit && !cfg_we && (!acc_q || (cnt_q == ns_q));
    assign val_o      = val_q;
    assign acc_o      = acc_q;
    assign ns_o       = ns_q;
endmodule

// File: rtl/lradc_arb.sv
// Request arbiter: collects slot starts, grants the lowest pending slot
// when the converter is idle and holds one request until done.
// Assumes done only arrives while a request is outstanding.
module lradc_arb #(
    parameter int SLOTS = 8,
    parameter int CH_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SLOTS-1:0]        start_i,
    input  logic [SLOTS-1:0]        en_i,
    input  logic [SLOTS*CH_W-1:0]   map_i,
    input  logic                    done_i,
    output logic                    req_o,
    output logic [CH_W-1:0]         chan_o,
    output logic [$clog2(SLOTS)-1:0] cur_o,
    output logic [SLOTS-1:0]        hit_o,
    output logic [SLOTS-1:0]        pend_o
);
    localparam int IDX_W = $clog2(SLOTS);

    logic [SLOTS-1:0] pend_q;
    logic             busy_q;
    logic [IDX_W-1:0] cur_q;
    logic [CH_W-1:0]  chan_q;
    logic [IDX_W-1:0] pick;
    logic             found;
    logic             grant;
    logic [SLOTS-1:0] grant_oh;

    // Find the lowest-index pending slot.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                pick  = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    assign grant    = !busy_q && found;
    assign grant_oh = grant ? (SLOTS'(1) << pick) : '0;

    // Track pending starts and the single outstanding request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            busy_q <= 1'b0;
            cur_q  <= '0;
            chan_q <= '0;
        end else begin
            pend_q <= (pend_q & ~grant_oh) | (start_i & en_i);
            if (grant) begin
                busy_q <= 1'b1;
                cur_q  <= pick;
                chan_q <= map_i[pick*CH_W +: CH_W];
            end else if (busy_q && done_i) begin
                busy_q <= 1'b0;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_hit
            assign hit_o[g] = busy_q && done_i && (cur_q == IDX_W'(g));
        end
    endgenerate

    assign req_o  = busy_q;
    assign chan_o = chan_q;
    assign cur_o  = cur_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/lradc_map_guard.sv
// Mapping validator: decides whether a candidate slot map and enable
// mask respect the inputs reserved by touch features and the slot budget.
// Purely combinational; assumes CHANS is at least 7.
module lradc_map_guard
    import lradc_bank_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int CHANS = 16,
    parameter int CH_W  = 4
) (
    input  logic [SLOTS*CH_W-1:0] map_i,
    input  logic [SLOTS-1:0]      mask_i,
    input  logic                  btn_i,
    input  panel_mode_e           panel_i,
    output logic                  ok_o
);
    logic [CHANS-1:0] rsv;
    logic [CHANS-1:0] used;
    int               nslots;
    int               nfeat;

    // Build the reserved set, the used set and the slot budget.
    always_comb begin
        rsv    = '0;
        used   = '0;
        nslots = 0;
        for (int c = 0; c < CHANS; c++) begin
            rsv[c] = (btn_i && c < 2)
                  || (panel_i == PANEL_FOUR && c >= 2 && c <= 5)
                  || (panel_i == PANEL_FIVE && c >= 2 && c <= 6);
        end
        for (int s = 0; s < SLOTS; s++) begin
            if (mask_i[s]) begin
                used[map_i[s*CH_W +: CH_W]] = 1'b1;
                nslots = nslots + 1;
            end
        end
        nfeat = (btn_i ? 1 : 0)
              + ((panel_i == PANEL_FOUR || panel_i == PANEL_FIVE) ? 1 : 0);
        ok_o  = ((used & rsv) == '0) && (nslots + nfeat <= SLOTS);
    end
endmodule

// File: rtl/lradc_bank.sv
// Top of the conversion result bank: register decode, slot map, enable
// mask, feature setup, interrupt flags, and the slot / arbiter / guard
// instances. Reads are combinational; writes take effect at the next edge.
module lradc_bank
    import lradc_bank_pkg::*;
#(
    parameter int NUM_SLOTS = BANK_SLOTS,
    parameter int NUM_CHANS = BANK_CHANS,
    parameter int VAL_W     = BANK_VAL_W,
    parameter int NS_W      = BANK_NS_W,
    parameter int NUM_EVT   = BANK_EVT,
    parameter int ADDR_W    = BANK_AW,
    parameter int DATA_W    = BANK_DW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_waddr,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic [ADDR_W-1:0]           bus_raddr,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_SLOTS-1:0]        trig_i,
    input  logic [NUM_EVT-1:0]          evt_i,
    output logic                        cnv_req_o,
    output logic [$clog2(NUM_CHANS)-1:0] cnv_chan_o,
    input  logic                        cnv_done_i,
    input  logic [VAL_W-1:0]            cnv_data_i,
    output logic                        irq_o
);
    localparam int CH_W  = $clog2(NUM_CHANS);
    localparam int IDX_W = $clog2(NUM_SLOTS);
    localparam int SRC   = NUM_SLOTS + NUM_EVT;
    localparam int MAP_W = NUM_SLOTS * CH_W;

    logic                 we_start, we_irq, we_clr, we_feat, we_mask, we_map;
    logic [NUM_SLOTS-1:0] we_slot;
    logic [MAP_W-1:0]     map_q;
    logic [NUM_SLOTS-1:0] mask_q;
    logic                 btn_q;
    panel_mode_e          panel_q;
    logic [SRC-1:0]       flag_q;
    logic [SRC-1:0]       en_q;
    logic [MAP_W-1:0]     cand_map;
    logic [NUM_SLOTS-1:0] cand_mask;
    logic                 map_ok;
    logic [NUM_SLOTS-1:0] start_vec;
    logic [NUM_SLOTS-1:0] hit_w;
    logic [NUM_SLOTS-1:0] done_w;
    logic [NUM_SLOTS-1:0] pend_w;
    logic [IDX_W-1:0]     cur_w;
    logic [VAL_W-1:0]     s_val [NUM_SLOTS];
    logic                 s_acc [NUM_SLOTS];
    logic [NS_W-1:0]      s_ns  [NUM_SLOTS];
    logic [SRC-1:0]       clr_vec;

    assign we_start = bus_we && (bus_waddr == ADDR_W'(ADR_START));
    assign we_irq   = bus_we && (bus_waddr == ADDR_W'(ADR_IRQ));
    assign we_clr   = bus_we && (bus_waddr == ADDR_W'(ADR_IRQ_CLR));
    assign we_feat  = bus_we && (bus_waddr == ADDR_W'(ADR_FEAT));
    assign we_mask  = bus_we && (bus_waddr == ADDR_W'(ADR_MASK));
    assign we_map   = bus_we && (bus_waddr == ADDR_W'(ADR_MAP));

    // Candidate state seen by the guard for a map or mask write.
    assign cand_map  = we_map  ? bus_wdata[MAP_W-1:0]     : map_q;
    assign cand_mask = we_mask ? bus_wdata[NUM_SLOTS-1:0] : mask_q;

    lradc_map_guard #(
        .SLOTS (NUM_SLOTS),
        .CHANS (NUM_CHANS),
        .CH_W  (CH_W)
    ) u_guard (
        .map_i   (cand_map),
        .mask_i  (cand_mask),
        .btn_i   (btn_q),
        .panel_i (panel_q),
        .ok_o    (map_ok)
    );

    // Configuration registers; map and mask only change when the guard agrees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q   <= '0;
            mask_q  <= '0;
            btn_q   <= 1'b0;
            panel_q <= PANEL_OFF;
        end else begin
            if (we_map && map_ok)
                map_q <= bus_wdata[MAP_W-1:0];
            if (we_mask && map_ok)
                mask_q <= bus_wdata[NUM_SLOTS-1:0];
            if (we_feat) begin
                btn_q   <= bus_wdata[0];
                panel_q <= panel_mode_e'(bus_wdata[2:1]);
            end
        end
    end

    assign start_vec = (we_start ? bus_wdata[NUM_SLOTS-1:0] : '0) | trig_i;

    lradc_arb #(
        .SLOTS (NUM_SLOTS),
        .CH_W  (CH_W)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_vec),
        .en_i    (mask_q),
        .map_i   (map_q),
        .done_i  (cnv_done_i),
        .req_o   (cnv_req_o),
        .chan_o  (cnv_chan_o),
        .cur_o   (cur_w),
        .hit_o   (hit_w),
        .pend_o  (pend_w)
    );

    genvar s;
    generate
        for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
            assign we_slot[s] = bus_we
                && (bus_waddr == ADDR_W'(ADR_SLOT0 + SLOT_STRIDE * s));
            lradc_slot #(
                .VAL_W (VAL_W),
                .NS_W  (NS_W)
            ) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .cfg_we     (we_slot[s]),
                .cfg_val    (bus_wdata[VAL_W-1:0]),
                .cfg_acc    (bus_wdata[ACC_BIT]),
                .cfg_ns     (bus_wdata[NS_LSB +: NS_W]),
                .hit        (hit_w[s]),
                .res        (cnv_data_i),
                .val_o      (s_val[s]),
                .acc_o      (s_acc[s]),
                .ns_o       (s_ns[s]),
                .complete_o (done_w[s])
            );
        end
    endgenerate

    assign clr_vec = we_clr ? bus_wdata[SRC-1:0] : '0;

    // Interrupt flags and enables; new events win over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_vec) | {evt_i, done_w};
            if (we_irq)
                en_q <= bus_wdata[EN_LSB +: SRC];
            else if (we_clr)
                en_q <= en_q & ~bus_wdata[EN_LSB +: SRC];
        end
    end

    assign irq_o = |(flag_q & en_q);

    // Combinational read mux over all visible registers.
    always_comb begin
        bus_rdata = '0;
        if (bus_raddr == ADDR_W'(ADR_IRQ)) begin
            bus_rdata[SRC-1:0]          = flag_q;
            bus_rdata[EN_LSB +: SRC]    = en_q;
        end else if (bus_raddr == ADDR_W'(ADR_FEAT)) begin
            bus_rdata[0]   = btn_q;
            bus_rdata[2:1] = panel_q;
        end else if (bus_raddr == ADDR_W'(ADR_MASK)) begin
            bus_rdata[NUM_SLOTS-1:0] = mask_q;
        end else if (bus_raddr == ADDR_W'(ADR_MAP)) begin
            bus_rdata[MAP_W-1:0] = map_q;
        end else begin
            for (int k = 0; k < NUM_SLOTS; k++) begin
                if (bus_raddr == ADDR_W'(ADR_SLOT0 + SLOT_STRIDE * k)) begin
                    bus_rdata[VAL_W-1:0]       = s_val[k];
                    bus_rdata[NS_LSB +: NS_W]  = s_ns[k];
                    bus_rdata[ACC_BIT]         = s_acc[k];
                end
            end
        end
    end
endmodule

// File: rtl/lradc_bank_chk.sv
// Property checker for the conversion result bank, bound to the top.
// Watches the converter handshake, grant order and guarded writes.
module lradc_bank_chk #(
    parameter int SLOTS = 8,
    parameter int CH_W  = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cnv_req,
    input logic                     cnv_done,
    input logic [CH_W-1:0]          cnv_chan,
    input logic                     irq,
    input logic [SLOTS*CH_W-1:0]    map,
    input logic [SLOTS-1:0]         mask,
    input logic [SLOTS-1:0]         pend,
    input logic [$clog2(SLOTS)-1:0] cur,
    input logic                     map_we,
    input logic                     mask_we,
    input logic                     map_ok
);
    localparam int IDX_W = $clog2(SLOTS);

    logic [SLOTS*CH_W-1:0] map_d;
    logic [SLOTS-1:0]      pend_d;
    logic [IDX_W-1:0]      low_d;

    // Keep one-cycle-old copies of the map and the pending set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_d  <= '0;
            pend_d <= '0;
        end else begin
            map_d  <= map;
            pend_d <= pend;
        end
    end

    // Lowest pending slot one cycle back.
    always_comb begin
        low_d = '0;
        for (int i = SLOTS - 1; i >= 0; i--)
            if (pend_d[i]) low_d = IDX_W'(i);
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!cnv_req && !irq));

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_req && !cnv_done) |=> (cnv_req && $stable(cnv_chan)));

    assert_chan_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_req) |-> (cnv_chan == map_d[cur*CH_W +: CH_W]));

    assert_lowest_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_req) |-> (cur == low_d));

    assert_map_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (map_we && !map_ok) |=> $stable(map));

    assert_mask_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && !map_ok) |=> $stable(mask));
endmodule

bind lradc_bank lradc_bank_chk #(
    .SLOTS (NUM_SLOTS),
    .CH_W  (CH_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnv_req  (cnv_req_o),
    .cnv_done (cnv_done_i),
    .cnv_chan (cnv_chan_o),
    .irq      (irq_o),
    .map      (map_q),
    .mask     (mask_q),
    .pend     (pend_w),
    .cur      (cur_w),
    .map_we   (we_map),
    .mask_we  (we_mask),
    .map_ok   (map_ok)
);

// File: tb/lradc_bank_tb.sv
`timescale 1ns/1ps
module lradc_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [8:0]  bus_waddr;
    logic [31:0] bus_wdata;
    logic [8:0]  bus_raddr;
    logic [31:0] bus_rdata;
    logic [7:0]  trig_i;
    logic [4:0]  evt_i;
    logic        cnv_req_o;
    logic [3:0]  cnv_chan_o;
    logic        cnv_done_i;
    logic [17:0] cnv_data_i;
    logic        irq_o;

    always #2.5 clk = ~clk;

    lradc_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .trig_i(trig_i), .evt_i(evt_i), .cnv_req_o(cnv_req_o),
        .cnv_chan_o(cnv_chan_o), .cnv_done_i(cnv_done_i),
        .cnv_data_i(cnv_data_i), .irq_o(irq_o)
    );

    int checks = 0;
    int errors = 0;
    bit ended  = 0;
    logic [3:0]  log_ch  [0:63];
    logic [17:0] log_dat [0:63];
    int          log_n = 0;
    logic [31:0] map_exp;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_raddr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 8) begin
            @(negedge clk);
            if (cnv_req_o || cnv_done_i) quiet = 0;
            else quiet++;
        end
    endtask

    // Index of the k-th set bit, counting upward from bit 0.
    function automatic int nth_bit(input logic [7:0] m, input int k);
        int seen = 0;
        for (int i = 0; i < 8; i++) begin
            if (m[i]) begin
                if (seen == k) return i;
                seen++;
            end
        end
        return -1;
    endfunction

    // Converter model: random latency, random 18-bit result, logged.
    initial begin
        cnv_done_i = 1'b0;
        cnv_data_i = '0;
        forever begin
            @(negedge clk);
            if (cnv_req_o) begin
                logic [3:0] ch;
                ch = cnv_chan_o;
                repeat ($urandom % 3) @(negedge clk);
                cnv_data_i = 18'($urandom);
                cnv_done_i = 1'b1;
                if (log_n < 64) begin
                    log_ch[log_n]  = ch;
                    log_dat[log_n] = cnv_data_i;
                end
                log_n++;
                @(negedge clk);
                cnv_done_i = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] sum;
        void'($urandom(32'h1A2B3C4D));
        rst_n = 1'b0; bus_we = 1'b0; bus_waddr = '0; bus_wdata = '0;
        bus_raddr = '0; trig_i = '0; evt_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 req", {31'b0, cnv_req_o}, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        rd(9'h010, r); chk("R1 irq reg", r, 32'h0);
        rd(9'h140, r); chk("R1 map", r, 32'h0);
        rd(9'h030, r); chk("R1 mask", r, 32'h0);
        rd(9'h080, r); chk("R1 slot3", r, 32'h0);
        rst_n = 1'b1;

        // Setup: all slots enabled, random map, no features.
        wr(9'h030, 32'hFF);
        map_exp = $urandom;
        wr(9'h140, map_exp);
        rd(9'h140, r); chk("R10 map accepted", r, map_exp);

        // R2/R3: single software start.
        log_n = 0;
        wr(9'h000, 32'h08);
        wait_idle();
        chk("R3 one conversion", log_n, 1);
        chk("R2 slot3 chan", {28'b0, log_ch[0]}, {28'b0, map_exp[15:12]});
        rd(9'h080, r); chk("R3 slot3 value", r, {14'b0, log_dat[0]});
        rd(9'h010, r); chk("R3 flag3", r & 32'h1FFF, 32'h8);

        // R7: several slots at once, lowest first.
        wr(9'h018, 32'h1FFF);
        log_n = 0;
        wr(9'h000, 32'hB4);
        wait_idle();
        chk("R7 count", log_n, 4);
        for (int k = 0; k < 4; k++) begin
            int idx;
            idx = nth_bit(8'hB4, k);
            chk("R7 order chan", {28'b0, log_ch[k]}, {28'b0, map_exp[idx*4 +: 4]});
            rd(9'(32'h50 + 32'h10 * idx), r);
            chk("R3 value", r, {14'b0, log_dat[k]});
        end

        // R6: trigger pulses.
        log_n = 0;
        @(negedge clk); trig_i = 8'h41;
        @(negedge clk); trig_i = 8'h00;
        wait_idle();
        chk("R6 trig count", log_n, 2);
        chk("R6 trig first", {28'b0, log_ch[0]}, {28'b0, map_exp[3:0]});
        chk("R6 trig second", {28'b0, log_ch[1]}, {28'b0, map_exp[27:24]});

        // Random phase: random maps and start masks, direct mode.
        for (int it = 0; it < 30; it++) begin
            logic [7:0] m;
            map_exp = $urandom;
            wr(9'h140, map_exp);
            m = 8'($urandom);
            if (m == 0) m = 8'h01;
            log_n = 0;
            if (it % 3 == 0) begin
                @(negedge clk); trig_i = m;
                @(negedge clk); trig_i = 8'h00;
            end else begin
                wr(9'h000, {24'b0, m});
            end
            wait_idle();
            chk("R7 random count", log_n, $countones(m));
            for (int k = 0; k < $countones(m); k++) begin
                int idx;
                idx = nth_bit(m, k);
                chk("R2 random chan", {28'b0, log_ch[k]}, {28'b0, map_exp[idx*4 +: 4]});
                rd(9'(32'h50 + 32'h10 * idx), r);
                chk("R3 random value", r, {14'b0, log_dat[k]});
            end
        end

        // R4: slot 1 accumulates 4 samples (count field 3).
        wr(9'h060, 32'h2300_0000);
        rd(9'h060, r); chk("R5 config readback", r, 32'h2300_0000);
        wr(9'h018, 32'h1FFF);
        sum = 0;
        for (int i = 0; i < 4; i++) begin
            log_n = 0;
            wr(9'h000, 32'h02);
            wait_idle();
            sum = sum + {14'b0, log_dat[0]};
            rd(9'h010, r);
            chk("R4 flag timing", r & 32'h2, (i == 3) ? 32'h2 : 32'h0);
        end
        rd(9'h060, r); chk("R4 sum", r & 32'h3FFFF, sum & 32'h3FFFF);

        // R5: rewrite mid-round restarts the counter.
        wr(9'h060, 32'h2300_0000);
        for (int i = 0; i < 2; i++) begin
            wr(9'h000, 32'h02);
            wait_idle();
        end
        wr(9'h060, 32'h2100_0100);
        wr(9'h018, 32'h1FFF);
        sum = 32'h100;
        for (int i = 0; i < 2; i++) begin
            log_n = 0;
            wr(9'h000, 32'h02);
            wait_idle();
            sum = sum + {14'b0, log_dat[0]};
            rd(9'h010, r);
            chk("R5 flag after restart", r & 32'h2, (i == 1) ? 32'h2 : 32'h0);
        end
        rd(9'h060, r); chk("R5 restarted sum", r & 32'h3FFFF, sum & 32'h3FFFF);
        wr(9'h060, 32'h0000_0005);
        rd(9'h060, r); chk("R5 direct load", r, 32'h5);

        // R6: disabled slot ignores starts.
        wr(9'h030, 32'h0F);
        wr(9'h018, 32'h1FFF);
        log_n = 0;
        wr(9'h000, 32'h40);
        @(negedge clk); trig_i = 8'h40;
        @(negedge clk); trig_i = 8'h00;
        wait_idle();
        chk("R6 disabled no conversion", log_n, 0);
        rd(9'h010, r); chk("R6 disabled no flag", r & 32'h40, 32'h0);
        wr(9'h030, 32'hFF);

        // R8/R9: interrupt enables, events and clear alias.
        wr(9'h018, 32'h1FFF);
        wr(9'h010, 32'h0008_0000);
        chk("R8 enable without flag", {31'b0, irq_o}, 32'h0);
        wr(9'h000, 32'h08);
        wait_idle();
        chk("R8 irq on enabled flag", {31'b0, irq_o}, 32'h1);
        wr(9'h018, 32'h0000_0008);
        chk("R9 irq after clear", {31'b0, irq_o}, 32'h0);
        rd(9'h010, r); chk("R9 enable kept", r, 32'h0008_0000);
        @(negedge clk); evt_i = 5'h01;
        @(negedge clk); evt_i = 5'h00;
        chk("R8 event masked", {31'b0, irq_o}, 32'h0);
        rd(9'h010, r); chk("R8 event flag", r, 32'h0008_0100);
        wr(9'h010, 32'h0108_0000);
        chk("R8 event enabled", {31'b0, irq_o}, 32'h1);
        wr(9'h018, 32'h0100_0000);
        chk("R9 enable cleared", {31'b0, irq_o}, 32'h0);
        rd(9'h010, r); chk("R9 reg after alias", r, 32'h0008_0100);

        // R10/R11: reservations.
        wr(9'h030, 32'h3F);
        wr(9'h140, 32'h00DC_BA98);
        wr(9'h020, 32'h3);
        wr(9'h140, 32'h00DC_BA91);
        rd(9'h140, r); chk("R10 button input rejected", r, 32'h00DC_BA98);
        wr(9'h140, 32'h00DC_BA96);
        rd(9'h140, r); chk("R10 input 6 free in four-wire", r, 32'h00DC_BA96);
        wr(9'h020, 32'h5);
        wr(9'h140, 32'h00DC_BAE6);
        rd(9'h140, r); chk("R10 input 6 taken in five-wire", r, 32'h00DC_BA96);
        wr(9'h140, 32'h00DC_BAE8);
        rd(9'h140, r); chk("R10 clean map accepted", r, 32'h00DC_BAE8);
        wr(9'h030, 32'hFF);
        rd(9'h030, r); chk("R11 ten slots rejected", r, 32'h3F);
        wr(9'h030, 32'h7F);
        rd(9'h030, r); chk("R11 nine slots rejected", r, 32'h3F);
        wr(9'h030, 32'h1F);
        rd(9'h030, r); chk("R11 seven slots accepted", r, 32'h1F);
        wr(9'h020, 32'h1);
        wr(9'h030, 32'h7F);
        rd(9'h030, r); chk("R10 slot6 on button input", r, 32'h1F);

        ended = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule